// File: doc/BRIEF.md
# Time-Slotted Transmit DMA Engine

This block feeds four transmit ports from one shared frame buffer memory that is 64 bits wide. A slot counter gives each port one cycle in a fixed rotation. In its slot a port may have one memory word read from the address that its port control logic presents. One cycle later the returned word is written into that port's transmit FIFO, together with a byte count and an end-of-frame flag. The line side drains these FIFOs independently.

A port forfeits its slot when it has no valid address, when its FIFO is full, or when it still has an ungranted buffer release. The slot is never handed to another port. When a stored word carries end-of-frame, the engine raises a release request for that port's frame control block. The index of that block was captured on the read that started the frame. A single release channel with a valid/ready handshake passes the pending requests on one at a time, in round-robin order.

Top module: `txdma_slot_engine`

## Requirements
- R1: Slots advance by one every cycle in the fixed order 0,1,2,3 and then repeat. Any read issued in a cycle serves only that slot's port, and `pc_ack` is zero or one-hot.
- R2: While `rst` is high there is no read and no acknowledge, every `tx_empty` bit is 1 and `rel_valid` is 0. The first cycle after `rst` falls is slot 0.
- R3: In port p's slot, when `pc_valid[p]` is high, its FIFO has room and it has no pending release, the engine raises `mem_rd_en` and `pc_ack[p]` in that same cycle. It also drives `mem_rd_addr` with bits `[p*ADDR_W +: ADDR_W]` of `pc_addr`.
- R4: When `pc_valid[p]` is low, or port p's FIFO already holds `FIFO_DEPTH` entries, the slot passes with no read and no acknowledge, and no other port uses it.
- R5: `mem_rd_data`, `mem_rd_eof` and `mem_rd_len` are sampled one cycle after the read and stored in the reading port's FIFO. A word with `mem_rd_eof` = 0 is stored with byte count 8 and end-of-frame flag 0.
- R6: A word returned with `mem_rd_eof` = 1 is stored with end-of-frame flag 1. Its byte count equals `mem_rd_len`, with 1 to 8 meaning that many valid bytes. `tx_bytes` gives 4 bits per port, at `[p*4 +: 4]`.
- R7: Storing an end-of-frame word makes a release pending for that port, and `rel_valid` can show it in the next cycle. `rel_fcb` carries the `pc_fcb` slice that was captured on that port's last read with `pc_sof` high.
- R8: The release channel offers one port at a time on `rel_port`/`rel_fcb`. While `rel_valid` is high and `rel_ready` is low, both are held stable. A handshake clears only that port's request. The next offer goes to the first pending port found by searching upward, wrapping round, from the port after the one last granted.
- R9: Each FIFO presents its oldest entry on `tx_data`/`tx_bytes`/`tx_eof`, and `tx_pop[p]` removes it. Entries leave in the order they were read.
- R10: A port whose release is pending forfeits its slots until the release is granted. After the grant it is served again in its next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_valid | input | NPORTS | Port control has a read address ready |
| pc_sof | input | NPORTS | Presented address starts a frame |
| pc_addr | input | NPORTS*ADDR_W | Read address per port, packed |
| pc_fcb | input | NPORTS*FCB_W | Frame control block index per port, packed |
| pc_ack | output | NPORTS | Read issued for this port this cycle |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | 64 | Memory word, one cycle after the read |
| mem_rd_eof | input | 1 | Returned word ends the frame |
| mem_rd_len | input | 4 | Valid bytes of an end-of-frame word |
| tx_pop | input | NPORTS | Line side takes the head entry |
| tx_data | output | NPORTS*64 | Head data per port |
| tx_bytes | output | NPORTS*4 | Head byte count per port |
| tx_eof | output | NPORTS | Head end-of-frame flag per port |
| tx_empty | output | NPORTS | FIFO empty per port |
| rel_valid | output | 1 | A release request is offered |
| rel_ready | input | 1 | Release channel accepts the offer |
| rel_port | output | $clog2(NPORTS) | Port of the offered release |
| rel_fcb | output | FCB_W | Frame control block to release |

## Verification
The critical coincidence is a release handshake for one port on the same clock edge that another port's end-of-frame word is stored and its request is set. The bench provokes it by holding port 0's release with `rel_ready` low, then issuing an end-of-frame read for port 2 and raising `rel_ready` for exactly the cycle in which port 2's word returns. It is judged correct when, in the following cycle, `rel_valid` is still high and names port 2 with port 2's block index. Both FIFOs must also hold their end-of-frame words with the right byte counts.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    localparam int WORD_W = 64;
    localparam int CNT_W  = 4;
    localparam logic [CNT_W-1:0] FULL_WORD_BYTES = 4'd8;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [CNT_W-1:0]  nbytes;
        logic              eof;
    } txq_entry_t;

    function automatic txq_entry_t make_entry(input logic [WORD_W-1:0] d,
                                              input logic              last,
                                              input logic [CNT_W-1:0]  len);
        txq_entry_t e;
        e.data   = d;
        e.nbytes = last ? len : FULL_WORD_BYTES;
        e.eof    = last;
        return e;
    endfunction

endpackage

// File: rtl/txdma_slot_seq.sv
module txdma_slot_seq #(
    parameter int NPORTS = 4,
    parameter int AW     = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NPORTS-1:0]          pc_valid,
    input  logic [NPORTS*AW-1:0]       pc_addr,
    input  logic [NPORTS-1:0]          room,
    input  logic [NPORTS-1:0]          rel_pend,
    output logic [$clog2(NPORTS)-1:0]  slot,
    output logic                       rd_en,
    output logic [AW-1:0]              rd_addr,
    output logic [NPORTS-1:0]          pc_ack
);
    localparam int PW = $clog2(NPORTS);

    logic [PW-1:0] slot_q;

    always_ff @(posedge clk) begin
        if (rst)                               slot_q <= '0;
        else if (slot_q == PW'(NPORTS - 1))    slot_q <= '0;
        else                                   slot_q <= slot_q + 1'b1;
    end

    always_comb begin
        rd_en   = !rst && pc_valid[slot_q] && room[slot_q] && !rel_pend[slot_q];
        rd_addr = pc_addr[slot_q*AW +: AW];
        pc_ack  = rd_en ? (NPORTS'(1) << slot_q) : '0;
    end

    assign slot = slot_q;

    // R1: at most one port served per cycle
    p_single_slot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pc_ack));

endmodule

// File: rtl/txdma_port_fifo.sv
module txdma_port_fifo
    import txdma_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        push,
    input  txq_entry_t                  push_entry,
    input  logic                        pop,
    output txq_entry_t                  head,
    output logic                        empty,
    output logic [$clog2(DEPTH+1)-1:0]  count
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    txq_entry_t        store_q [DEPTH];
    logic [IW-1:0]     wr_q, rd_q;
    logic [CW-1:0]     cnt_q;
    logic              do_push, do_pop;

    assign do_pop  = pop && (cnt_q != '0);
    assign do_push = push && (cnt_q != CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= (wr_q == IW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (do_pop)  rd_q <= (rd_q == IW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) store_q[wr_q] <= push_entry;
    end

    assign head  = store_q[rd_q];
    assign empty = (cnt_q == '0);
    assign count = cnt_q;

    // R5: the slot logic never sends a word into a full FIFO
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt_q < CW'(DEPTH)));

endmodule

// File: rtl/txdma_release_arb.sv
module txdma_release_arb #(
    parameter int NPORTS = 4,
    parameter int FW     = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NPORTS-1:0]          set_req,
    input  logic [NPORTS*FW-1:0]       fcb_flat,
    input  logic                       rel_ready,
    output logic [NPORTS-1:0]          pend,
    output logic                       rel_valid,
    output logic [$clog2(NPORTS)-1:0]  rel_port,
    output logic [FW-1:0]              rel_fcb
);
    localparam int PW = $clog2(NPORTS);

    logic [NPORTS-1:0] pend_q, clr_vec;
    logic [PW-1:0]     ptr_q, lock_port_q, pick, choice;
    logic              lock_q, found, take;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < NPORTS; i++) begin
            int idx;
            idx = int'(ptr_q) + i;
            if (idx >= NPORTS) idx = idx - NPORTS;
            if (!found && pend_q[idx]) begin
                found = 1'b1;
                pick  = PW'(idx);
            end
        end
        choice    = lock_q ? lock_port_q : pick;
        rel_valid = |pend_q;
        take      = rel_valid && rel_ready;
        clr_vec   = take ? (NPORTS'(1) << choice) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= '0;
            ptr_q       <= '0;
            lock_q      <= 1'b0;
            lock_port_q <= '0;
        end else begin
            pend_q      <= (pend_q & ~clr_vec) | set_req;
            if (take) ptr_q <= (choice == PW'(NPORTS - 1)) ? '0 : choice + 1'b1;
            lock_q      <= rel_valid && !rel_ready;
            lock_port_q <= choice;
        end
    end

    assign pend     = pend_q;
    assign rel_port = choice;
    assign rel_fcb  = fcb_flat[choice*FW +: FW];

    // R8: an offer stays put until it is taken
    p_hold_offer_r8: assert property (@(posedge clk) disable iff (rst)
        (rel_valid && !rel_ready) |=> (rel_valid && $stable(rel_port) && $stable(rel_fcb)));

    // R8: one grant per handshake
    p_one_grant_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_vec));

    // R7: a stored end-of-frame word leaves a pending request behind
    p_eof_sets_pending_r7: assert property (@(posedge clk) disable iff (rst)
        (|set_req) |=> ((pend_q & $past(set_req)) == $past(set_req)));

endmodule

// File: rtl/txdma_slot_engine.sv
module txdma_slot_engine
    import txdma_pkg::*;
#(
    parameter int NPORTS     = 4,
    parameter int ADDR_W     = 16,
    parameter int FCB_W      = 10,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NPORTS-1:0]           pc_valid,
    input  logic [NPORTS-1:0]           pc_sof,
    input  logic [NPORTS*ADDR_W-1:0]    pc_addr,
    input  logic [NPORTS*FCB_W-1:0]     pc_fcb,
    output logic [NPORTS-1:0]           pc_ack,
    output logic                        mem_rd_en,
    output logic [ADDR_W-1:0]           mem_rd_addr,
    input  logic [63:0]                 mem_rd_data,
    input  logic                        mem_rd_eof,
    input  logic [3:0]                  mem_rd_len,
    input  logic [NPORTS-1:0]           tx_pop,
    output logic [NPORTS*64-1:0]        tx_data,
    output logic [NPORTS*4-1:0]         tx_bytes,
    output logic [NPORTS-1:0]           tx_eof,
    output logic [NPORTS-1:0]           tx_empty,
    output logic                        rel_valid,
    input  logic                        rel_ready,
    output logic [$clog2(NPORTS)-1:0]   rel_port,
    output logic [FCB_W-1:0]            rel_fcb
);
    localparam int PW = $clog2(NPORTS);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic [PW-1:0]       slot;
    logic [NPORTS-1:0]   room, pend, push_vec, set_req;
    logic                infl_v_q;
    logic [PW-1:0]       infl_port_q;
    logic [CW-1:0]       cnt [NPORTS];
    txq_entry_t          head [NPORTS];
    txq_entry_t          new_entry;
    logic [FCB_W-1:0]    fcb_q [NPORTS];
    logic [NPORTS*FCB_W-1:0] fcb_flat;

    txdma_slot_seq #(.NPORTS(NPORTS), .AW(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .pc_valid (pc_valid),
        .pc_addr  (pc_addr),
        .room     (room),
        .rel_pend (pend),
        .slot     (slot),
        .rd_en    (mem_rd_en),
        .rd_addr  (mem_rd_addr),
        .pc_ack   (pc_ack)
    );

    // one word in flight: memory answers one cycle after the read
    always_ff @(posedge clk) begin
        if (rst) begin
            infl_v_q    <= 1'b0;
            infl_port_q <= '0;
        end else begin
            infl_v_q    <= mem_rd_en;
            infl_port_q <= slot;
        end
    end

    always_comb begin
        push_vec = '0;
        if (infl_v_q) push_vec[infl_port_q] = 1'b1;
    end

    assign new_entry = make_entry(mem_rd_data, mem_rd_eof, mem_rd_len);
    assign set_req   = mem_rd_eof ? push_vec : '0;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        txdma_port_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
            .clk        (clk),
            .rst        (rst),
            .push       (push_vec[p]),
            .push_entry (new_entry),
            .pop        (tx_pop[p]),
            .head       (head[p]),
            .empty      (tx_empty[p]),
            .count      (cnt[p])
        );

        assign room[p]               = cnt[p] < CW'(FIFO_DEPTH);
        assign tx_data[p*64 +: 64]   = head[p].data;
        assign tx_bytes[p*4 +: 4]    = head[p].nbytes;
        assign tx_eof[p]             = head[p].eof;
        assign fcb_flat[p*FCB_W +: FCB_W] = fcb_q[p];

        always_ff @(posedge clk) begin
            if (rst)                          fcb_q[p] <= '0;
            else if (pc_ack[p] && pc_sof[p])  fcb_q[p] <= pc_fcb[p*FCB_W +: FCB_W];
        end
    end

    txdma_release_arb #(.NPORTS(NPORTS), .FW(FCB_W)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .set_req   (set_req),
        .fcb_flat  (fcb_flat),
        .rel_ready (rel_ready),
        .pend      (pend),
        .rel_valid (rel_valid),
        .rel_port  (rel_port),
        .rel_fcb   (rel_fcb)
    );

    // R4: a read is only issued when the slot's FIFO can take the word
    p_room_on_read_r4: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> (cnt[slot] < CW'(FIFO_DEPTH)));

    // R10: a port with an ungranted release is never read
    p_blocked_by_release_r10: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> !pend[slot]);

    // R5: every read is followed by exactly one FIFO write
    p_push_after_read_r5: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> $onehot(push_vec));

endmodule

// File: tb/tb_txdma_slot_engine.sv
`timescale 1ns/1ps
module tb_txdma_slot_engine;

    localparam int  N     = 4;
    localparam int  AW    = 16;
    localparam int  FW    = 10;
    localparam int  DEPTH = 4;
    localparam time CLK_P = 20;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    pc_valid = '0;
    logic [N-1:0]    pc_sof = '0;
    logic [AW-1:0]   addr_b [N];
    logic [FW-1:0]   fcb_b [N];
    logic [N*AW-1:0] pc_addr;
    logic [N*FW-1:0] pc_fcb;
    logic [N-1:0]    pc_ack;
    logic            mem_rd_en;
    logic [AW-1:0]   mem_rd_addr;
    logic [63:0]     mem_rd_data = '0;
    logic            mem_rd_eof = 1'b0;
    logic [3:0]      mem_rd_len = '0;
    logic [N-1:0]    tx_pop = '0;
    logic [N*64-1:0] tx_data;
    logic [N*4-1:0]  tx_bytes;
    logic [N-1:0]    tx_eof, tx_empty;
    logic            rel_valid;
    logic            rel_ready = 1'b0;
    logic [1:0]      rel_port;
    logic [FW-1:0]   rel_fcb;

    int tests = 0;
    int fails = 0;
    int last_gnt = 0;

    assign pc_addr = {addr_b[3], addr_b[2], addr_b[1], addr_b[0]};
    assign pc_fcb  = {fcb_b[3], fcb_b[2], fcb_b[1], fcb_b[0]};

    always #(CLK_P/2) clk = ~clk;

    txdma_slot_engine #(.NPORTS(N), .ADDR_W(AW), .FCB_W(FW), .FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .pc_valid(pc_valid), .pc_sof(pc_sof), .pc_addr(pc_addr),
        .pc_fcb(pc_fcb), .pc_ack(pc_ack), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data), .mem_rd_eof(mem_rd_eof), .mem_rd_len(mem_rd_len),
        .tx_pop(tx_pop), .tx_data(tx_data), .tx_bytes(tx_bytes), .tx_eof(tx_eof),
        .tx_empty(tx_empty), .rel_valid(rel_valid), .rel_ready(rel_ready),
        .rel_port(rel_port), .rel_fcb(rel_fcb)
    );

    // memory word pattern; bit 15 of the address marks end-of-frame,
    // bits 2:0 plus one give its byte count
    function automatic logic [63:0] word_of(input logic [15:0] a);
        return {a, ~a, a ^ 16'h5A5A, a + 16'h0001};
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= word_of(mem_rd_addr);
            mem_rd_eof  <= mem_rd_addr[15];
            mem_rd_len  <= {1'b0, mem_rd_addr[2:0]} + 4'd1;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int rr_next(input int ptr, input logic [3:0] mask);
        for (int i = 0; i < N; i++) begin
            int k;
            k = (ptr + i) % N;
            if (mask[k]) return k;
        end
        return -1;
    endfunction

    task automatic wait_ack(input int p, input string req);
        bit seen;
        seen = 1'b0;
        #1;
        if (pc_ack[p]) seen = 1'b1;
        for (int i = 0; i < 8 && !seen; i++) begin
            @(negedge clk); #1;
            if (pc_ack[p]) seen = 1'b1;
        end
        chk(req, "ack seen for port", 64'(seen), 64'd1);
    endtask

    task automatic pop_check(input int p, input logic [63:0] exp_d,
                             input logic [3:0] exp_n, input logic exp_e, input string req);
        chk(req, "fifo not empty", 64'(tx_empty[p]), 64'd0);
        chk(req, "head data", tx_data[p*64 +: 64], exp_d);
        chk(req, "head bytes", 64'(tx_bytes[p*4 +: 4]), 64'(exp_n));
        chk(req, "head eof", 64'(tx_eof[p]), 64'(exp_e));
        tx_pop[p] = 1'b1;
        @(negedge clk); #1;
        tx_pop[p] = 1'b0;
    endtask

    // R2: reset state and first slot
    task automatic t_reset;
        for (int p = 0; p < N; p++) begin
            addr_b[p] = 16'h0100 * 16'(p + 1);
            fcb_b[p]  = '0;
        end
        pc_valid = '1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R2", "no read in reset", 64'(mem_rd_en), 64'd0);
        chk("R2", "no ack in reset", 64'(pc_ack), 64'd0);
        chk("R2", "fifos empty", 64'(tx_empty), 64'hF);
        chk("R2", "no release", 64'(rel_valid), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R2", "first slot is port 0", 64'(pc_ack), 64'h1);
    endtask

    // R1 R3 R4 R5 R9: rotation with all ports asking, until FIFOs fill
    task automatic t_rotation;
        int acks, rot_err, addr_err, prev;
        acks = 0; rot_err = 0; addr_err = 0; prev = -1;
        for (int i = 0; i < 24; i++) begin
            if (i > 0) begin
                @(negedge clk); #1;
                if (prev >= 0) addr_b[prev] = addr_b[prev] + 16'd1;
            end
            prev = -1;
            if (pc_ack != '0) begin
                for (int p = 0; p < N; p++) if (pc_ack[p]) prev = p;
                if (acks > 0 && pc_ack != 4'(1 << ((acks) % N))) rot_err++;
                if (acks == 0 && pc_ack != 4'h1) rot_err++;
                if (mem_rd_addr !== addr_b[prev]) addr_err++;
                acks++;
            end
        end
        pc_valid = '0;
        chk("R1", "rotation order errors", 64'(rot_err), 64'd0);
        chk("R3", "address mux errors", 64'(addr_err), 64'd0);
        chk("R4", "reads stop once FIFOs full", 64'(acks), 64'(N * DEPTH));
        @(negedge clk); #1;
        for (int p = 0; p < N; p++)
            for (int k = 0; k < DEPTH; k++)
                pop_check(p, word_of(16'h0100 * 16'(p + 1) + 16'(k)), 4'd8, 1'b0, "R5_R9");
        chk("R9", "all drained", 64'(tx_empty), 64'hF);
    endtask

    // R4: no valid address means no read
    task automatic t_idle;
        int reads;
        reads = 0;
        pc_valid = '0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #1;
            if (mem_rd_en) reads++;
        end
        chk("R4", "idle reads", 64'(reads), 64'd0);
    endtask

    // R6 R7 R8 R10: one end-of-frame, release held, then granted
    task automatic t_single_release;
        int blocked_acks, moved;
        addr_b[1] = 16'h8002; fcb_b[1] = 10'h123; pc_sof[1] = 1'b1;
        @(negedge clk);
        pc_valid[1] = 1'b1;
        wait_ack(1, "R3");
        chk("R3", "eof address", 64'(mem_rd_addr), 64'h8002);
        @(negedge clk); #1;
        pc_valid[1] = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R7", "release offered", 64'(rel_valid), 64'd1);
        chk("R7", "release port", 64'(rel_port), 64'd1);
        chk("R7", "release fcb", 64'(rel_fcb), 64'h123);
        pop_check(1, word_of(16'h8002), 4'd3, 1'b1, "R6");
        addr_b[1] = 16'h0200; fcb_b[1] = 10'h055; pc_valid[1] = 1'b1;
        blocked_acks = 0; moved = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #1;
            if (pc_ack[1]) blocked_acks++;
            if (!rel_valid || rel_port != 2'd1 || rel_fcb != 10'h123) moved++;
        end
        chk("R10", "reads while release pending", 64'(blocked_acks), 64'd0);
        chk("R8", "offer held without ready", 64'(moved), 64'd0);
        rel_ready = 1'b1;
        @(negedge clk); #1;
        rel_ready = 1'b0;
        last_gnt = 1;
        chk("R8", "offer cleared by handshake", 64'(rel_valid), 64'd0);
        wait_ack(1, "R10");
        @(negedge clk); #1;
        pc_valid[1] = 1'b0; pc_sof[1] = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        pop_check(1, word_of(16'h0200), 4'd8, 1'b0, "R10");
    endtask

    // R8: three ports pending, round-robin grant order
    task automatic t_round_robin;
        int order [3];
        int n;
        logic [3:0] done, remaining;
        logic [FW-1:0] exp_fcb [N];
        logic [15:0]   eaddr [N];
        eaddr[0] = 16'h8007; eaddr[2] = 16'h8000; eaddr[3] = 16'h8005; eaddr[1] = 16'h0;
        exp_fcb[0] = 10'h0A0; exp_fcb[2] = 10'h2A2; exp_fcb[3] = 10'h3A3; exp_fcb[1] = 10'h0;
        @(negedge clk);
        for (int p = 0; p < N; p++) begin
            if (p != 1) begin
                addr_b[p] = eaddr[p]; fcb_b[p] = exp_fcb[p];
                pc_sof[p] = 1'b1; pc_valid[p] = 1'b1;
            end
        end
        n = 0; done = '0;
        for (int i = 0; i < 8; i++) begin
            if (i > 0) @(negedge clk);
            #1;
            for (int p = 0; p < N; p++) if (done[p]) pc_valid[p] = 1'b0;
            for (int p = 0; p < N; p++)
                if (pc_ack[p] && n < 3) begin done[p] = 1'b1; order[n] = p; n++; end
        end
        pc_valid = '0; pc_sof = '0;
        chk("R3", "three eof reads", 64'(n), 64'd3);
        repeat (3) @(negedge clk);
        #1;
        chk("R8", "first offer is first stored", 64'(rel_port), 64'(order[0]));
        remaining = 4'b1101;
        rel_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            int e;
            e = (i == 0) ? order[0] : rr_next((last_gnt + 1) % N, remaining);
            chk("R8", "grant valid", 64'(rel_valid), 64'd1);
            chk("R8", "round-robin port", 64'(rel_port), 64'(e));
            chk("R7", "granted fcb", 64'(rel_fcb), 64'(exp_fcb[e]));
            remaining[e] = 1'b0;
            last_gnt = e;
            @(negedge clk); #1;
        end
        rel_ready = 1'b0;
        chk("R8", "all released", 64'(rel_valid), 64'd0);
        pop_check(0, word_of(16'h8007), 4'd8, 1'b1, "R6");
        pop_check(2, word_of(16'h8000), 4'd1, 1'b1, "R6");
        pop_check(3, word_of(16'h8005), 4'd6, 1'b1, "R6");
    endtask

    // R7 R8: grant of port 0 on the same edge that port 2's request is set
    task automatic t_grant_meets_set;
        addr_b[0] = 16'h8003; fcb_b[0] = 10'h0F0; pc_sof[0] = 1'b1;
        @(negedge clk);
        pc_valid[0] = 1'b1;
        wait_ack(0, "R3");
        @(negedge clk); #1;
        pc_valid[0] = 1'b0; pc_sof[0] = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R7", "port 0 offered", 64'(rel_port), 64'd0);
        addr_b[2] = 16'h8001; fcb_b[2] = 10'h222; pc_sof[2] = 1'b1;
        pc_valid[2] = 1'b1;
        wait_ack(2, "R3");
        @(negedge clk); #1;
        pc_valid[2] = 1'b0; pc_sof[2] = 1'b0;
        chk("R8", "port 0 still offered", 64'(rel_port), 64'd0);
        rel_ready = 1'b1;
        @(negedge clk); #1;
        rel_ready = 1'b0;
        chk("R7", "new request survives grant", 64'(rel_valid), 64'd1);
        chk("R8", "next offer port 2", 64'(rel_port), 64'd2);
        chk("R7", "port 2 fcb", 64'(rel_fcb), 64'h222);
        rel_ready = 1'b1;
        @(negedge clk); #1;
        rel_ready = 1'b0;
        chk("R8", "channel idle", 64'(rel_valid), 64'd0);
        pop_check(0, word_of(16'h8003), 4'd4, 1'b1, "R6");
        pop_check(2, word_of(16'h8001), 4'd2, 1'b1, "R6");
    endtask

    initial begin
        #(CLK_P * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int p = 0; p < N; p++) begin
            addr_b[p] = '0;
            fcb_b[p]  = '0;
        end
        @(negedge clk);
        t_reset();
        t_rotation();
        t_idle();
        t_single_release();
        t_round_robin();
        t_grant_meets_set();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule